// File: doc/BRIEF.md
# Controller Pack Vibration Command Sequencer

This block produces the serial write frames that prepare and control the vibration motor in a controller accessory pack. A client asks for one of three actions: prepare the pack, switch the motor on, or switch it off. It does this with a single-cycle request strobe and a 2-bit select code. The block then clocks out a frame of 35 bytes on a single open-drain data line. Each frame is one write command byte, two address bytes and a 32-byte payload that repeats one value, and it closes with a stop bit. A `busy` flag covers the whole transmission. A one-cycle `done` pulse marks the moment the line has been let go after the stop bit.

The line is never driven high. The block only asserts an enable that pulls the pad low, and the pad's pull-up supplies the high level. Bits are pulse-width coded in 4 µs cells. The cell length comes from a clock-frequency parameter. The motor frames only take effect after the preparation frame has been sent, and only packs that contain a motor react to them.

Top module: `rumble_seq`

## Requirements
- R1: After reset, and for as long as no frame is being sent, `line_low` is 0, `busy` is 0 and `done` is 0.
- R2: Select code 0 (prepare) sends the bytes 0x03, 0x80, 0x01 and then 32 bytes of 0x80.
- R3: Select code 1 (motor on) sends the bytes 0x03, 0xC0, 0x1B and then 32 bytes of 0x01.
- R4: Select code 2 (motor off) sends the bytes 0x03, 0xC0, 0x1B and then 32 bytes of 0x00.
- R5: Each frame holds exactly 280 data bits, 35 bytes sent most-significant bit first, followed by exactly one stop pulse. That makes 281 low pulses per frame.
- R6: Every bit cell spans 4 µs, which is 4·CLK_HZ/1e6 cycles between successive falling edges of the line. A 0 holds the line low for 3 µs. A 1 holds it low for 1 µs.
- R7: The stop bit holds the line low for 1 µs and then releases it. `done` is then high for exactly one cycle while the line is released and `busy` is 0.
- R8: A request that arrives while `busy` is high is dropped. No further frame follows the current one.
- R9: The select code is captured when a frame starts. Changing `sel` or requesting again mid-frame does not alter the frame in progress.
- R10: Select code 3 is not a valid action. A request carrying it starts nothing: `busy` stays 0 and the line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request strobe |
| sel | input | 2 | Action: 0 prepare, 1 motor on, 2 motor off, 3 invalid |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse after the line is released at frame end |
| line_low | output | 1 | Registered open-drain enable: 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume that `rst` is synchronous and held for at least one clock edge. They also assume that CLK_HZ is a whole multiple of 1 MHz of at least 1 MHz, so that a microsecond is a whole number of cycles. Beyond that they assume nothing about `req` or `sel`. A strobe may come at any time, including mid-frame and with an invalid code, and the latched action must stay fixed regardless. The stimulus changes inputs only on the falling clock edge, keeps the default 4 MHz clock, and deliberately sends strobes with a different select code while a frame is in flight.

// File: rtl/rumble_pkg.sv
package rumble_pkg;
  localparam int FRAME_BYTES = 35;
  localparam int IDX_W = 6;

  localparam logic [1:0] ACT_PREP = 2'd0;
  localparam logic [1:0] ACT_ON   = 2'd1;
  localparam logic [1:0] ACT_OFF  = 2'd2;
  localparam logic [1:0] ACT_BAD  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_STOP = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

  // Byte value at a given frame position for a given action.
  function automatic logic [7:0] frame_byte(input logic [1:0] act, input logic [IDX_W-1:0] idx);
    logic [7:0] v;
    if (idx == '0)                 v = 8'h03;
    else if (idx == IDX_W'(1))     v = (act == ACT_PREP) ? 8'h80 : 8'hC0;
    else if (idx == IDX_W'(2))     v = (act == ACT_PREP) ? 8'h01 : 8'h1B;
    else if (act == ACT_PREP)      v = 8'h80;
    else if (act == ACT_ON)        v = 8'h01;
    else                           v = 8'h00;
    return v;
  endfunction
endpackage

// File: rtl/rumble_slot_timer.sv
module rumble_slot_timer #(
  parameter int US_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run,
  output logic [1:0] quarter,
  output logic       slot_end
);
  localparam int CNT_W = (US_CYC > 1) ? $clog2(US_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(US_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign slot_end = run && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      quarter <= 2'd0;
    end else if (run) begin
      if (cnt == CNT_LAST) begin
        cnt     <= '0;
        quarter <= quarter + 2'd1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // Each microsecond slot ends by advancing to the next quarter of the cell.
  assert_quarter_step_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_end && !clr) |=> (quarter == 2'($past(quarter) + 2'd1)));
endmodule

// File: rtl/rumble_frame_ctr.sv
module rumble_frame_ctr
  import rumble_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  output logic [IDX_W-1:0] byte_idx,
  output logic [2:0]       bit_idx,
  output logic             last_bit
);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(FRAME_BYTES - 1);

  assign last_bit = (byte_idx == LAST_BYTE) && (bit_idx == 3'd0);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      byte_idx <= '0;
      bit_idx  <= 3'd7;
    end else if (adv && !last_bit) begin
      bit_idx <= bit_idx - 3'd1;
      if (bit_idx == 3'd0) byte_idx <= byte_idx + IDX_W'(1);
    end
  end

  assert_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (bit_idx == 3'd7 && byte_idx == '0));
  assert_byte_bound_R5: assert property (@(posedge clk) disable iff (rst)
    byte_idx <= LAST_BYTE);
endmodule

// File: rtl/rumble_seq.sv
module rumble_seq
  import rumble_pkg::*;
#(
  parameter int CLK_HZ = 4_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [1:0] sel,
  output logic       busy,
  output logic       done,
  output logic       line_low
);
  localparam int US_CYC = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  seq_state_e       state;
  logic [1:0]       act_q;
  logic [1:0]       quarter;
  logic             slot_end;
  logic [IDX_W-1:0] byte_idx;
  logic [2:0]       bit_idx;
  logic             last_bit;
  logic [7:0]       cur_byte;
  logic             cur_bit;
  logic             start;
  logic             bit_end;
  logic             drive_c;

  assign start   = (state == ST_IDLE) && req && (sel != ACT_BAD);
  assign bit_end = (state == ST_BIT) && slot_end && (quarter == 2'd3);

  rumble_slot_timer #(.US_CYC(US_CYC)) timer_i (
    .clk(clk), .rst(rst), .clr(start),
    .run((state == ST_BIT) || (state == ST_STOP)),
    .quarter(quarter), .slot_end(slot_end)
  );

  rumble_frame_ctr frame_i (
    .clk(clk), .rst(rst), .start(start), .adv(bit_end),
    .byte_idx(byte_idx), .bit_idx(bit_idx), .last_bit(last_bit)
  );

  assign cur_byte = frame_byte(act_q, byte_idx);
  assign cur_bit  = cur_byte[bit_idx];

  // Low for the first quarter always; also the middle two for a zero.
  assign drive_c = ((state == ST_BIT) &&
                    ((quarter == 2'd0) || ((quarter != 2'd3) && !cur_bit))) ||
                   ((state == ST_STOP) && (quarter == 2'd0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      act_q <= ACT_PREP;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_BIT;
          act_q <= sel;
        end
        ST_BIT:  if (bit_end && last_bit) state <= ST_STOP;
        ST_STOP: if (slot_end) state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_low <= 1'b0;
      done     <= 1'b0;
    end else begin
      line_low <= drive_c;
      done     <= (state == ST_FIN);
    end
  end

  assign busy = (state != ST_IDLE);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state == ST_IDLE)) |-> !line_low);
  assert_done_released_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!line_low && !busy));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_action_held_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state != ST_IDLE)) |-> $stable(act_q));
  assert_bad_code_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && req && sel == ACT_BAD) |=> (state == ST_IDLE));
endmodule

// File: tb/rumble_seq_tb_top.sv
module rumble_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 4_000_000;
  localparam int US = HZ / 1_000_000;
  localparam int NPULSE = 281;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [1:0] sel = 2'd0;
  logic busy, done, line_low;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  int widths [0:299];
  int npulse;
  int period_err;
  bit saw_done;
  bit done_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  rumble_seq #(.CLK_HZ(HZ)) dut_i (
    .clk(clk), .rst(rst), .req(req), .sel(sel),
    .busy(busy), .done(done), .line_low(line_low)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // Send one request and capture the low-pulse widths until done.
  task automatic capture(input logic [1:0] s, input bit disturb, input logic [1:0] other);
    bit prev = 1'b0;
    int low = 0;
    int since = 0;
    int nfall = 0;
    npulse = 0; period_err = 0; saw_done = 0; done_ok = 0;
    @(negedge clk); req = 1'b1; sel = s;
    @(negedge clk); req = 1'b0;
    for (int c = 0; c < 8000; c++) begin
      @(negedge clk);
      if (disturb && c == 300) begin req = 1'b1; sel = other; end
      if (disturb && c == 301) req = 1'b0;
      if (disturb && c == 302) sel = 2'd3;
      since++;
      if (line_low && !prev) begin
        if (nfall > 0 && since != 4*US) period_err++;
        nfall++;
        since = 0;
        low = 0;
      end
      if (line_low) low++;
      if (!line_low && prev && npulse < 300) begin
        widths[npulse] = low;
        npulse++;
      end
      prev = line_low;
      if (done) begin
        saw_done = 1;
        done_ok = !line_low && !busy;
        break;
      end
    end
  endtask

  task automatic check_frame(input string rq, input logic [7:0] b1, input logic [7:0] b2,
                             input logic [7:0] pay);
    int mism = 0;
    for (int i = 0; i < 280 && i < npulse; i++) begin
      logic [7:0] bv;
      logic eb;
      int eb_w;
      bv = (i < 8) ? 8'h03 : (i < 16) ? b1 : (i < 24) ? b2 : pay;
      eb = bv[7 - (i % 8)];
      eb_w = eb ? US : 3*US;
      if (widths[i] != eb_w) mism++;
    end
    chk(mism == 0, rq, mism, 0);
    chk(npulse == NPULSE, "R5 pulse count", npulse, NPULSE);
    chk(period_err == 0, "R6 cell period", period_err, 0);
    chk(npulse > 0 && widths[npulse-1] == US, "R7 stop width",
        (npulse > 0) ? widths[npulse-1] : -1, US);
    chk(saw_done && done_ok, "R7 done with line released", int'(done_ok), 1);
    @(negedge clk);
    chk(!done, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !line_low, "R1 reset state",
        {busy, done, line_low}, 0);
  endtask

  task automatic t_prep();
    capture(2'd0, 1'b0, 2'd0);
    check_frame("R2 prepare frame", 8'h80, 8'h01, 8'h80);
  endtask

  task automatic t_on_disturbed();
    capture(2'd1, 1'b1, 2'd0);
    check_frame("R3 R9 motor-on frame under mid-frame request", 8'hC0, 8'h1B, 8'h01);
    begin
      int activity = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (busy || line_low) activity++;
      end
      chk(activity == 0, "R8 dropped request", activity, 0);
    end
  endtask

  task automatic t_off();
    capture(2'd2, 1'b0, 2'd0);
    check_frame("R4 motor-off frame", 8'hC0, 8'h1B, 8'h00);
  endtask

  task automatic t_bad_code();
    int activity = 0;
    @(negedge clk); req = 1'b1; sel = 2'd3;
    @(negedge clk); req = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (busy || line_low) activity++;
    end
    chk(activity == 0, "R10 invalid code ignored", activity, 0);
    chk(!busy && !line_low && !done, "R1 idle after invalid code",
        {busy, done, line_low}, 0);
  endtask

  initial begin
    t_reset();
    t_bad_code();
    t_prep();
    t_on_disturbed();
    t_off();
    t_prep();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule